// File: doc/BRIEF.md
# DMA Completion Byte Tracker

This block decides when a DMA transfer is finished. Each transfer is opened on a tag slot. Opening it records the transfer's length in bytes and the number of cycles by which its completion notice is held back. Each response that comes back for that transfer carries the tag and the byte count of the request that produced it. The count is the requested size, not the possibly rounded-up size that was returned. The tracker adds that count to the slot's running total.

When the running total reaches the transfer length, the transfer is finished. The outstanding-transfer count drops at once, and the slot starts its delay timer. When the timer expires, a one-cycle completion pulse carries the tag, and only then can the slot be opened again. Responses on a tag that is not collecting bytes, and responses that would push the total past the length, are reported on error pulses. When a completion brings the outstanding count to zero, a drain pulse is raised.

Top module: `dma_done_tracker`

## Requirements
- R1: After reset the outstanding count is 0 and `done_valid`, `drain_done`, `err_tag` and `err_over` are all low.
- R2: An allocate on a free slot opens it and raises `outstanding` by one at the next edge. An allocate on a slot that is still collecting or still waiting out its delay is ignored and leaves `outstanding` unchanged.
- R3: A response whose tag is not collecting bytes raises `err_tag` for one cycle after the edge that samples it. It changes no count.
- R4: Each accepted response adds `rsp_bytes` (the requested size) to the slot total. A transfer completes only on the response that makes the total exactly equal to its length; earlier partial responses leave `outstanding` unchanged.
- R5: A response that would make the total exceed the length raises `err_over` for one cycle and is discarded. The slot keeps its previous total and stays open.
- R6: `outstanding` decreases by one at the edge that samples the completing response, once per transfer.
- R7: With a delay of D, `done_valid` is high with `done_tag` equal to the transfer's tag for one cycle, D+1 edges after the edge that samples the completing response.
- R8: When a completion brings `outstanding` from 1 to 0, `drain_done` pulses high for one cycle at that same edge.
- R9: An accepted allocate and a completion at the same edge leave `outstanding` unchanged, and no drain pulse is raised.
- R10: When several slots are due to complete at the same edge, the lowest tag is reported first and each other slot is reported at a later edge, one per edge.
- R11: A slot can be allocated again once its completion pulse has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Open a transfer this cycle |
| alloc_tag | input | 2 | Slot to open |
| alloc_len | input | 16 | Transfer length in bytes |
| alloc_delay | input | 8 | Completion delay in cycles |
| rsp_valid | input | 1 | A response is present |
| rsp_tag | input | 2 | Slot the response belongs to |
| rsp_bytes | input | 16 | Requested byte count of the response |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | 2 | Tag of the completed transfer |
| drain_done | output | 1 | Nothing is left outstanding after a completion |
| outstanding | output | 3 | Number of open transfers |
| err_tag | output | 1 | Response on a tag that is not collecting bytes |
| err_over | output | 1 | Response would exceed the transfer length |

## Verification
The count and the error and drain pulses are registered, so they are due at the first edge after the response or allocate that causes them. A completion notice is due D+1 edges after the completing response. The bench drives inputs on falling edges and reads outputs at the next falling edge. For the completion notice, it also checks each intermediate falling edge, so that the pulse must appear neither early nor late. When two completions fall due at the same edge, one is checked per edge in tag order.

// File: rtl/dma_done_tracker.sv
module dma_done_tracker #(
  parameter int TAGS  = 4,
  parameter int LEN_W = 16,
  parameter int DLY_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [$clog2(TAGS)-1:0]   alloc_tag,
  input  logic [LEN_W-1:0]          alloc_len,
  input  logic [DLY_W-1:0]          alloc_delay,
  input  logic                      rsp_valid,
  input  logic [$clog2(TAGS)-1:0]   rsp_tag,
  input  logic [LEN_W-1:0]          rsp_bytes,
  output logic                      done_valid,
  output logic [$clog2(TAGS)-1:0]   done_tag,
  output logic                      drain_done,
  output logic [$clog2(TAGS+1)-1:0] outstanding,
  output logic                      err_tag,
  output logic                      err_over
);
  localparam int TAG_W = $clog2(TAGS);
  localparam int CNT_W = $clog2(TAGS+1);

  logic [TAGS-1:0]  busy, pend;
  logic [LEN_W-1:0] tot [TAGS];
  logic [LEN_W-1:0] acc [TAGS];
  logic [DLY_W-1:0] tmr [TAGS];

  logic           alloc_ok, rsp_live, over, fin, fire_any;
  logic [LEN_W:0] sum;
  logic [TAG_W-1:0] fire_tag;

  assign alloc_ok = alloc_valid && !busy[alloc_tag] && !pend[alloc_tag];
  assign rsp_live = rsp_valid && busy[rsp_tag];
  assign sum      = {1'b0, acc[rsp_tag]} + {1'b0, rsp_bytes};
  assign over     = rsp_live && (sum > {1'b0, tot[rsp_tag]});
  assign fin      = rsp_live && (sum == {1'b0, tot[rsp_tag]});

  always_comb begin
    fire_any = 1'b0;
    fire_tag = '0;
    for (int i = TAGS-1; i >= 0; i--)
      if (pend[i] && tmr[i] == '0) begin
        fire_any = 1'b1;
        fire_tag = TAG_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      pend <= '0;
      for (int i = 0; i < TAGS; i++) begin
        tot[i] <= '0;
        acc[i] <= '0;
        tmr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < TAGS; i++) begin
        if (alloc_ok && alloc_tag == TAG_W'(i)) begin
          busy[i] <= 1'b1;
          tot[i]  <= alloc_len;
          acc[i]  <= '0;
          tmr[i]  <= alloc_delay;
        end
        if (rsp_live && rsp_tag == TAG_W'(i) && !over) begin
          acc[i] <= sum[LEN_W-1:0];
          if (fin) begin
            busy[i] <= 1'b0;
            pend[i] <= 1'b1;
          end
        end
        if (pend[i] && tmr[i] != '0) tmr[i] <= tmr[i] - 1'b1;
        if (fire_any && fire_tag == TAG_W'(i)) pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      done_valid  <= 1'b0;
      done_tag    <= '0;
      drain_done  <= 1'b0;
      err_tag     <= 1'b0;
      err_over    <= 1'b0;
    end else begin
      outstanding <= outstanding + CNT_W'(alloc_ok) - CNT_W'(fin);
      done_valid  <= fire_any;
      done_tag    <= fire_tag;
      drain_done  <= fin && !alloc_ok && outstanding == CNT_W'(1);
      err_tag     <= rsp_valid && !busy[rsp_tag];
      err_over    <= over;
    end
  end

  p_cnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CNT_W'(TAGS));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding == $past(outstanding)) ||
    (outstanding == $past(outstanding) + CNT_W'(1)) ||
    (outstanding + CNT_W'(1) == $past(outstanding)));

  p_drain_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> outstanding == '0);

  p_drain_from_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> $past(outstanding) == CNT_W'(1));

  p_over_no_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_over |-> !drain_done && !err_tag);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && $past(done_valid)) |-> done_tag != $past(done_tag));
endmodule

// File: tb/test_dma_done_tracker.sv
module test_dma_done_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_tag = '0;
  logic [15:0] alloc_len = '0;
  logic [7:0]  alloc_delay = '0;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_tag = '0;
  logic [15:0] rsp_bytes = '0;
  logic        done_valid, drain_done, err_tag, err_over;
  logic [1:0]  done_tag;
  logic [2:0]  outstanding;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  dma_done_tracker i_dma_done_tracker (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
    .alloc_len(alloc_len), .alloc_delay(alloc_delay),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_bytes(rsp_bytes),
    .done_valid(done_valid), .done_tag(done_tag), .drain_done(drain_done),
    .outstanding(outstanding), .err_tag(err_tag), .err_over(err_over)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic alloc(logic [1:0] t, logic [15:0] len, logic [7:0] dly);
    alloc_valid = 1'b1; alloc_tag = t; alloc_len = len; alloc_delay = dly;
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic rsp(logic [1:0] t, logic [15:0] b);
    rsp_valid = 1'b1; rsp_tag = t; rsp_bytes = b;
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "outstanding", int'(outstanding), 0);
    check("R1", "done_valid", int'(done_valid), 0);
    check("R1", "drain_done", int'(drain_done), 0);
    check("R1", "errors", int'(err_tag | err_over), 0);
  endtask

  task automatic t_single_with_delay();
    alloc(2'd0, 16'd64, 8'd3);
    check("R2", "count after alloc", int'(outstanding), 1);
    alloc(2'd0, 16'd8, 8'd0);
    check("R2", "busy slot alloc ignored", int'(outstanding), 1);
    rsp(2'd2, 16'd4);
    check("R3", "err_tag on idle tag", int'(err_tag), 1);
    check("R3", "count unchanged", int'(outstanding), 1);
    rsp(2'd0, 16'd32);
    check("R4", "partial keeps count", int'(outstanding), 1);
    check("R3", "err_tag low on live tag", int'(err_tag), 0);
    rsp(2'd0, 16'd48);
    check("R5", "err_over", int'(err_over), 1);
    check("R5", "count unchanged", int'(outstanding), 1);
    rsp(2'd0, 16'd32);
    check("R5", "total kept, completes at 64", int'(outstanding), 0);
    check("R6", "count drops at completion", int'(outstanding), 0);
    check("R8", "drain pulse", int'(drain_done), 1);
    check("R7", "no early done", int'(done_valid), 0);
    alloc(2'd0, 16'd8, 8'd0);
    check("R11", "alloc during delay ignored", int'(outstanding), 0);
    check("R8", "drain single cycle", int'(drain_done), 0);
    check("R7", "no done at +1", int'(done_valid), 0);
    step();
    check("R7", "no done at +2", int'(done_valid), 0);
    step();
    check("R7", "no done at +3", int'(done_valid), 0);
    step();
    check("R7", "done at +4", int'(done_valid), 1);
    check("R7", "done tag", int'(done_tag), 0);
    alloc(2'd0, 16'd8, 8'd0);
    check("R7", "done single cycle", int'(done_valid), 0);
    check("R11", "realloc after done", int'(outstanding), 1);
    rsp(2'd0, 16'd8);
    check("R11", "reused slot completes", int'(outstanding), 0);
    step();
    check("R7", "zero-delay done", int'(done_valid), 1);
  endtask

  task automatic t_requested_size();
    alloc(2'd1, 16'd40, 8'd0);
    rsp(2'd1, 16'd16);
    rsp(2'd1, 16'd16);
    check("R4", "not done at 32 of 40", int'(outstanding), 1);
    rsp(2'd1, 16'd8);
    check("R4", "done at exactly 40", int'(outstanding), 0);
    check("R4", "no overflow", int'(err_over), 0);
    step();
    check("R4", "done tag 1", int'(done_tag), 1);
    check("R4", "done valid", int'(done_valid), 1);
  endtask

  task automatic t_alloc_and_finish();
    alloc(2'd1, 16'd16, 8'd0);
    alloc(2'd2, 16'd16, 8'd0);
    alloc_valid = 1'b1; alloc_tag = 2'd3; alloc_len = 16'd16; alloc_delay = 8'd0;
    rsp_valid = 1'b1; rsp_tag = 2'd1; rsp_bytes = 16'd16;
    step();
    alloc_valid = 1'b0; rsp_valid = 1'b0;
    check("R9", "count unchanged", int'(outstanding), 2);
    check("R9", "no drain", int'(drain_done), 0);
    step();
    check("R9", "done tag 1", int'(done_tag), 1);
    rsp(2'd2, 16'd16);
    check("R6", "count 1", int'(outstanding), 1);
    rsp(2'd3, 16'd16);
    check("R8", "drain at zero", int'(drain_done), 1);
    step();
    check("R7", "done tag 3", int'(done_tag), 3);
  endtask

  task automatic t_tie();
    alloc(2'd3, 16'd8, 8'd1);
    alloc(2'd0, 16'd8, 8'd0);
    rsp(2'd3, 16'd8);
    rsp(2'd0, 16'd8);
    check("R10", "no done yet", int'(done_valid), 0);
    step();
    check("R10", "first valid", int'(done_valid), 1);
    check("R10", "lowest tag first", int'(done_tag), 0);
    step();
    check("R10", "second valid", int'(done_valid), 1);
    check("R10", "then tag 3", int'(done_tag), 3);
    step();
    check("R10", "then idle", int'(done_valid), 0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    t_reset();
    t_single_with_delay();
    t_requested_size();
    t_alloc_and_finish();
    t_tie();
    ended = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule